// File: doc/BRIEF.md
# Two-Way Cache Tag Directory with Miss Classification

This block models only the tags of a cache with 256 block frames. The frames form 128 sets of two ways each, and victims are chosen by least-recently-used order. A client presents one memory block number in each cycle that has a valid strobe. One cycle later the block reports whether that access hit. A miss is reported as a first-reference miss (compulsory) or as a miss on a block that was used before and has since been pushed out (conflict). The block holds no data, issues no fill requests and has no write policy. It decides only residency and the outcome of each access.

The directory keeps a valid bit and a tag for every way, and one recency bit for every set. A separate bit map records every block number that has ever been presented. Three saturating event counters run next to the result path. Software can zero them with a synchronous clear, which does not disturb the directory. The intended use is to profile access streams, for example to measure how many misses come from set contention and how many come from cold starts.

Top module: `cache_tag_dir`

## Requirements
- R1: After reset every way is invalid, every block counts as never referenced, all three counters read 0 and `res_valid` is low.
- R2: The set index is `block_num[6:0]` and the tag is `block_num[8:7]`. Blocks that differ only in bits 8:7 compete for the same two ways.
- R3: An access sampled at a clock edge with `access_valid` high drives `res_valid` high after that edge, with exactly one of `res_hit`, `res_miss_compulsory` and `res_miss_conflict` high. A cycle with `access_valid` low gives `res_valid` low and all flags low, and it leaves the counters unchanged.
- R4: An access hits when its tag is valid in either way of its set.
- R5: On a miss, an invalid way of the set is filled if one exists, way 0 first. Otherwise the least-recently-used way is replaced.
- R6: A hit and a fill both make the accessed way the most recently used way of its set.
- R7: A miss on a block number never presented since reset is compulsory. A miss on a block presented before is conflict.
- R8: Each counter (`hit_count`, `compulsory_count`, `conflict_count`) grows by one at the same edge on which its result flag is registered.
- R9: The counters are 16 bits wide and hold at 65535 instead of wrapping.
- R10: `cnt_clear` zeroes all counters at the next edge and overrides an access counted in that same cycle. The access is still looked up, reported and applied to the directory.
- R11: From reset, the 16-access stream 0,128,256,128,0,128,256,128,1,129,257,129,1,129,257,129, applied ten times, gives 4 conflict misses on the first pass and 8 on each later pass. That is 76 conflict, 6 compulsory and 78 hits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_valid | input | 1 | An access is presented this cycle |
| block_num | input | 9 | Memory block number of the access |
| cnt_clear | input | 1 | Synchronous clear of the three counters |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_hit | output | 1 | That access hit |
| res_miss_compulsory | output | 1 | That access missed on a never-referenced block |
| res_miss_conflict | output | 1 | That access missed on a previously referenced block |
| hit_count | output | 16 | Saturating hit count |
| compulsory_count | output | 16 | Saturating compulsory-miss count |
| conflict_count | output | 16 | Saturating conflict-miss count |

## Verification
Every block number is swept twice, once upward and once downward. The result of each access is compared with a model that follows the requirements. A design that picked the wrong victim, or that failed to refresh recency on a hit, would report hits where conflicts are expected. Directed same-set triples check the LRU order and the compulsory/conflict split with values worked out by hand. A history bit that was cleared on eviction would turn conflicts into compulsory misses. The 76-conflict stream is checked pass by pass. A clear that coincides with a hit shows whether the clear wins over counting and whether the directory survives it. A run of 65537 hits exposes a counter that wraps.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_COMP = 2'd2,
        OUT_CONF = 2'd3
    } outcome_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic comp;
        logic conf;
    } result_t;

endpackage

// File: rtl/dir_ways.sv
module dir_ways #(
    parameter int SET_W = 7,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    output logic             look_hit
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 2;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0]                      lru;  // way to evict next
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic [WAYS-1:0] way_hit;
    logic            victim;
    logic            use_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = st_q.vld[req_set][w] && (st_q.tag[req_set][w] == req_tag);
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.vld[req_set][0])      victim = 1'b0;
        else if (!st_q.vld[req_set][1]) victim = 1'b1;
        else                            victim = st_q.lru[req_set];
        if (way_hit[1])      use_way = 1'b1;
        else if (way_hit[0]) use_way = 1'b0;
        else                 use_way = victim;
        look_hit = req_valid && (way_hit != '0);
        if (req_valid) begin
            st_d.vld[req_set][use_way] = 1'b1;
            st_d.tag[req_set][use_way] = req_tag;
            st_d.lru[req_set]          = ~use_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the way just touched is no longer the eviction candidate
    a_r6_lru_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (st_q.lru[$past(req_set)] != $past(use_way)));

    // R5: after any access the set holds the accessed tag in a valid way
    a_r5_tag_resident: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (st_q.vld[$past(req_set)][$past(use_way)] &&
                       st_q.tag[$past(req_set)][$past(use_way)] == $past(req_tag)));

    // R4: a tag is never resident in both ways of a set
    a_r4_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !(way_hit[0] && way_hit[1]));

endmodule

// File: rtl/dir_history.sv
module dir_history #(
    parameter int BLK_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    output logic             seen
);
    localparam int BLKS = 1 << BLK_W;

    typedef struct packed {
        logic [BLKS-1:0] refd;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        seen = st_q.refd[req_blk];
        if (req_valid) st_d.refd[req_blk] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a presented block is remembered from the next cycle on
    a_r7_marked: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> st_q.refd[$past(req_blk)]);

    // R7: history bits are never cleared outside reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> st_q.refd[$past(req_blk)]);

endmodule

// File: rtl/dir_counters.sv
module dir_counters #(
    parameter int CNT_W = 16,
    parameter int NCNT  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [NCNT-1:0]            inc,
    output logic [NCNT-1:0][CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NCNT-1:0][CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCNT; i++) begin
            if (clear)                              st_d.cnt[i] = '0;
            else if (inc[i] && st_q.cnt[i] != CMAX) st_d.cnt[i] = st_q.cnt[i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    for (genvar i = 0; i < NCNT; i++) begin : g_chk
        // R9: a full counter stays full
        a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && st_q.cnt[i] == CMAX) |=> st_q.cnt[i] == CMAX);
        // R8: counters move by at most one per cycle
        a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (st_q.cnt[i] == $past(st_q.cnt[i]) ||
                        st_q.cnt[i] == $past(st_q.cnt[i]) + 1'b1));
        // R10: clear empties the counter
        a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> st_q.cnt[i] == '0);
    end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int BLK_W = 9,
    parameter int SET_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access_valid,
    input  logic [BLK_W-1:0] block_num,
    input  logic             cnt_clear,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss_compulsory,
    output logic             res_miss_conflict,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] compulsory_count,
    output logic [CNT_W-1:0] conflict_count
);
    localparam int TAG_W = BLK_W - SET_W;
    localparam int NCNT  = 3;

    logic                       look_hit;
    logic                       seen;
    outcome_e                   outcome;
    result_t                    res_d, res_q;
    logic [NCNT-1:0]            inc;
    logic [NCNT-1:0][CNT_W-1:0] counts;

    dir_ways #(.SET_W(SET_W), .TAG_W(TAG_W)) i_ways (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (access_valid),
        .req_set   (block_num[SET_W-1:0]),
        .req_tag   (block_num[BLK_W-1:SET_W]),
        .look_hit  (look_hit)
    );

    dir_history #(.BLK_W(BLK_W)) i_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (access_valid),
        .req_blk   (block_num),
        .seen      (seen)
    );

    always_comb begin
        if (!access_valid) outcome = OUT_NONE;
        else if (look_hit) outcome = OUT_HIT;
        else if (seen)     outcome = OUT_CONF;
        else               outcome = OUT_COMP;
        res_d.valid = (outcome != OUT_NONE);
        res_d.hit   = (outcome == OUT_HIT);
        res_d.comp  = (outcome == OUT_COMP);
        res_d.conf  = (outcome == OUT_CONF);
        inc = {res_d.conf, res_d.comp, res_d.hit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    dir_counters #(.CNT_W(CNT_W), .NCNT(NCNT)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (inc),
        .count (counts)
    );

    assign res_valid           = res_q.valid;
    assign res_hit             = res_q.hit;
    assign res_miss_compulsory = res_q.comp;
    assign res_miss_conflict   = res_q.conf;
    assign hit_count           = counts[0];
    assign compulsory_count    = counts[1];
    assign conflict_count      = counts[2];

    // R3: a result follows every access, and only accesses
    a_r3_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid |=> res_valid);
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !access_valid |=> !res_valid && !res_hit && !res_miss_compulsory && !res_miss_conflict);
    // R3: exactly one outcome flag on a result
    a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss_compulsory, res_miss_conflict}) == 1);
    // R8: a registered hit flag came with a counter step unless cleared or full
    a_r8_hit_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (access_valid && !cnt_clear && hit_count != {CNT_W{1'b1}}) |=>
            (res_hit == (hit_count == $past(hit_count) + 1'b1)));

endmodule

// File: tb/test_cache_tag_dir.sv
module test_cache_tag_dir;
    localparam int CLK_PERIOD = 10;
    localparam int BLKS = 512;
    localparam int SETS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        access_valid = 1'b0;
    logic [8:0]  block_num = '0;
    logic        cnt_clear = 1'b0;
    logic        res_valid, res_hit, res_miss_compulsory, res_miss_conflict;
    logic [15:0] hit_count, compulsory_count, conflict_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_tag_dir i_cache_tag_dir (
        .clk(clk), .rst_n(rst_n), .access_valid(access_valid), .block_num(block_num),
        .cnt_clear(cnt_clear), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss_compulsory(res_miss_compulsory), .res_miss_conflict(res_miss_conflict),
        .hit_count(hit_count), .compulsory_count(compulsory_count),
        .conflict_count(conflict_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference state: 0 hit, 1 compulsory, 2 conflict
    bit m_vld [SETS][2];
    int m_tag [SETS][2];
    bit m_lru [SETS];
    bit m_seen[BLKS];
    int e_cnt [3];

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
        end
        for (int b = 0; b < BLKS; b++) m_seen[b] = 0;
        for (int i = 0; i < 3; i++) e_cnt[i] = 0;
    endtask

    task automatic model_step(input int b, output int cls);
        int s, t, w;
        s = b % SETS;
        t = b / SETS;
        if (m_vld[s][0] && m_tag[s][0] == t) begin cls = 0; w = 0; end
        else if (m_vld[s][1] && m_tag[s][1] == t) begin cls = 0; w = 1; end
        else begin
            cls = m_seen[b] ? 2 : 1;
            w = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_lru[s]));
        end
        m_vld[s][w] = 1; m_tag[s][w] = t; m_lru[s] = (w == 0);
        m_seen[b] = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; access_valid = 1'b0; cnt_clear = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    // call at a negedge; returns at the negedge where the result is visible
    task automatic do_access(input int b, input bit clr, output int cls);
        model_step(b, cls);
        access_valid = 1'b1; block_num = 9'(b); cnt_clear = clr;
        @(posedge clk);
        @(negedge clk);
        access_valid = 1'b0; cnt_clear = 1'b0;
        if (clr) for (int i = 0; i < 3; i++) e_cnt[i] = 0;
        else if (e_cnt[cls] < 65535) e_cnt[cls]++;
        chk("R3 res_valid", res_valid, 1);
        chk("R4 hit flag", res_hit, cls == 0);
        chk("R7 compulsory flag", res_miss_compulsory, cls == 1);
        chk("R7 conflict flag", res_miss_conflict, cls == 2);
    endtask

    task automatic chk_counts(input string req);
        chk({req, " hit_count"}, hit_count, e_cnt[0]);
        chk({req, " compulsory_count"}, compulsory_count, e_cnt[1]);
        chk({req, " conflict_count"}, conflict_count, e_cnt[2]);
    endtask

    task automatic expect_cls(input int b, input int exp, input string req);
        int c;
        do_access(b, 1'b0, c);
        chk(req, c, exp);
        chk({req, " flags"}, {res_hit, res_miss_compulsory, res_miss_conflict},
            exp == 0 ? 3'b100 : (exp == 1 ? 3'b010 : 3'b001));
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_cmp++; n_bad++;
                $display("FAIL R3 watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin : stimulus
        int c;
        int seq[16] = '{0,128,256,128,0,128,256,128,1,129,257,129,1,129,257,129};

        do_reset();
        // R1: reset state
        chk("R1 res_valid after reset", res_valid, 0);
        chk_counts("R1");

        // R11: stream applied ten times, counts derived by hand
        for (int p = 0; p < 10; p++) begin
            for (int k = 0; k < 16; k++) begin
                do_access(seq[k], 1'b0, c);
                chk_counts("R8");
            end
            chk("R11 conflicts after pass", conflict_count, 4 + 8 * p);
        end
        chk("R11 total conflicts", conflict_count, 76);
        chk("R11 total compulsory", compulsory_count, 6);
        chk("R11 total hits", hit_count, 78);

        // R3: idle cycles with a moving block number change nothing
        for (int k = 0; k < 4; k++) begin
            block_num = 9'(k * 37);
            @(posedge clk); @(negedge clk);
            chk("R3 idle res_valid", res_valid, 0);
            chk("R3 idle flags", {res_hit, res_miss_compulsory, res_miss_conflict}, 0);
        end
        chk_counts("R3 idle");

        // R10: clear together with a hit on resident block 128
        do_access(128, 1'b1, c);
        chk("R10 access still reported as hit", res_hit, 1);
        chk_counts("R10 cleared");
        do_access(128, 1'b0, c);
        chk("R10 directory kept", res_hit, 1);
        chk("R10 count restarts", hit_count, 1);

        // R2, R5, R6, R7: directed triples in set 3
        do_reset();
        expect_cls(3,   1, "R7 first 3");
        expect_cls(131, 1, "R5 131 fills free way");
        expect_cls(3,   0, "R4 3 still resident");
        expect_cls(259, 1, "R2 259 same set new block");
        expect_cls(3,   0, "R6 3 kept by recency");
        expect_cls(131, 2, "R7 131 evicted earlier");
        expect_cls(259, 2, "R6 259 evicted as LRU");
        expect_cls(4,   1, "R2 other set untouched");
        chk_counts("R8 directed");

        // R1, R2, R5, R6, R7: exhaustive sweeps against the model
        do_reset();
        for (int b = 0; b < BLKS; b++) do_access(b, 1'b0, c);
        chk("R1 every first touch compulsory", compulsory_count, 512);
        for (int b = 0; b < BLKS; b++) do_access(b, 1'b0, c);
        for (int b = BLKS - 1; b >= 0; b--) do_access(b, 1'b0, c);
        chk_counts("R8 sweep");

        // R9: saturation with a long run of hits on block 0
        do_access(0, 1'b1, c);
        access_valid = 1'b1; block_num = 9'd0;
        for (int k = 0; k < 65537; k++) @(posedge clk);
        @(negedge clk);
        access_valid = 1'b0;
        chk("R9 hit_count saturates", hit_count, 65535);
        chk("R9 other counters untouched", compulsory_count + conflict_count, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 held after run", hit_count, 65535);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule